// File: doc/BRIEF.md
# Mersenne Twister Word Stream Source

This block is a pseudo-random number source that runs the Mersenne Twister algorithm in hardware. It sends one tempered word per beat on an AXI4-Stream master output made of `m_tdata`, `m_tvalid` and `m_tready`. A parameter selects the word width. With 32 bits the state is 624 words. With 64 bits the state is 312 words, and the seed recurrence, twist masks, offsets and tempering constants change with it. The whole state sits in an on-chip memory with registered reads.

Each output word is regenerated when it is needed. The twist for index `k` is applied just before word `k` is tempered and presented, so there is never a bulk regeneration pass. The index wraps from the last state word back to 0.

Seeding fills the memory one word per cycle from the seed recurrence. It starts from the `INIT_SEED` parameter after reset, or from `seed_val` when `seed_start` is pulsed. The `busy` output is high while seeding runs, and no word is offered during that time. A consumer can stall the stream at any time without losing or repeating words.

Top module: `mt_stream_gen`

## Requirements
- R1: While reset is held, `busy` is 1 and `m_tvalid` is 0. After reset is released, the stream is the reference sequence for the seed `INIT_SEED`, which defaults to 5489. This also holds when reset is applied in the middle of a stream.
- R2: After reset is released, `busy` stays high for N-1 more cycles, where N is 624 for 32-bit words. After a `seed_start` pulse, `busy` is high for N cycles. `m_tvalid` is 0 whenever `busy` is 1.
- R3: With 32-bit words and the default seed, the first word offered is 0xD091BB5C.
- R4: Seeding sets word 0 to the seed, and each later word i to 1812433253*(w ^ (w>>30)) + i mod 2^32, where w is word i-1. The twist builds y from bit 31 of word k and bits 30..0 of word k+1 (for k=623 the second word is word 0). The new word k is word (k+397 mod 624) ^ (y>>1), and is further XORed with 0x9908B0DF when y is odd. Tempering applies the shifts 11, 7 with mask 0x9D2C5680, 15 with mask 0xEFC60000, and 18, in that order. The stream matches this sequence past the wrap of the index.
- R5: A one-cycle `seed_start` pulse with `seed_val` alongside restarts seeding, and the stream that follows is the reference sequence for `seed_val`.
- R6: A `seed_start` pulse that arrives while `busy` is high restarts seeding. Only the last seed value determines the stream that follows.
- R7: While `m_tvalid` is 1 and `m_tready` is 0, `m_tvalid` stays 1 and `m_tdata` holds its value.
- R8: Under any pattern of `m_tready`, every word of the reference sequence is delivered exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts seeding from INIT_SEED |
| seed_val | input | MT_W | Seed value sampled with seed_start |
| seed_start | input | 1 | One-cycle pulse that starts reseeding |
| busy | output | 1 | High while the state memory is being seeded |
| m_tdata | output | MT_W | Tempered output word |
| m_tvalid | output | 1 | Output word valid |
| m_tready | input | 1 | Consumer ready |

## Verification
Seeding takes one cycle to load word 0 and then one cycle per remaining word. The bench therefore expects `busy` to be observed high at 623 falling edges after reset is released, and at 624 falling edges after the edge that samples a seed pulse. Without a stall, each word becomes valid two cycles after the previous handshake or after seeding ends. The bench does not count a fixed latency for this. It samples on falling edges and takes a word only on a falling edge where `m_tvalid` is seen together with the `m_tready` value it has just driven, so the transfer happens at the next rising edge. While a stall lasts, every falling edge compares `m_tdata` with the value captured when the stall began. Expected words come from a bench-side model that regenerates the whole state in one batch, which is not the per-word method the block uses.

// File: rtl/mt_pkg.sv
package mt_pkg;

  typedef enum logic [2:0] {
    ST_LOAD,
    ST_SEED,
    ST_READ,
    ST_CALC,
    ST_SEND
  } mt_state_e;

  // state words held for a given word width
  function automatic int mt_words(input int w);
    return (w == 64) ? 312 : 624;
  endfunction

  // distance to the partner word used by the twist
  function automatic int mt_mid(input int w);
    return (w == 64) ? 156 : 397;
  endfunction

  function automatic int mt_seed_shift(input int w);
    return (w == 64) ? 62 : 30;
  endfunction

  function automatic logic [63:0] mt_seed_mult(input int w);
    return (w == 64) ? 64'd6364136223846793005 : 64'd1812433253;
  endfunction

  function automatic logic [63:0] mt_odd_xor(input int w);
    return (w == 64) ? 64'hB5026F5AA96619E9 : 64'h0000_0000_9908_B0DF;
  endfunction

endpackage

// File: rtl/mt_state_ram.sv
module mt_state_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 624,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end

  // R4: every write lands inside the state memory
  waddr_range_chk: assert property (@(posedge clk) we |-> (waddr < AW'(DEPTH)));

endmodule

// File: rtl/mt_twist_unit.sv
module mt_twist_unit #(
  parameter int W = 32
) (
  input  logic [W-1:0] word_k,
  input  logic [W-1:0] word_k1,
  input  logic [W-1:0] word_far,
  output logic [W-1:0] word_new,
  output logic [W-1:0] tempered
);
  import mt_pkg::*;

  localparam logic [W-1:0] ODD_XOR = W'(mt_odd_xor(W));

  logic [W-1:0] y;

  always_comb begin
    y        = {word_k[W-1:31], word_k1[30:0]};
    word_new = word_far ^ (y >> 1) ^ (y[0] ? ODD_XOR : '0);
  end

  generate
    if (W == 64) begin : g_tmp64
      logic [W-1:0] t1, t2, t3;
      always_comb begin
        t1       = word_new ^ ((word_new >> 29) & W'(64'h5555555555555555));
        t2       = t1 ^ ((t1 << 17) & W'(64'h71D67FFFEDA60000));
        t3       = t2 ^ ((t2 << 37) & W'(64'hFFF7EEE000000000));
        tempered = t3 ^ (t3 >> 43);
      end
    end else begin : g_tmp32
      logic [W-1:0] t1, t2, t3;
      always_comb begin
        t1       = word_new ^ (word_new >> 11);
        t2       = t1 ^ ((t1 << 7) & W'(32'h9D2C5680));
        t3       = t2 ^ ((t2 << 15) & W'(32'hEFC60000));
        tempered = t3 ^ (t3 >> 18);
      end
    end
  endgenerate

endmodule

// File: rtl/mt_stream_gen.sv
module mt_stream_gen #(
  parameter int               MT_W      = 32,
  parameter logic [MT_W-1:0]  INIT_SEED = MT_W'(5489)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [MT_W-1:0] seed_val,
  input  logic            seed_start,
  output logic            busy,
  output logic [MT_W-1:0] m_tdata,
  output logic            m_tvalid,
  input  logic            m_tready
);
  import mt_pkg::*;

  localparam int N   = mt_words(MT_W);
  localparam int M   = mt_mid(MT_W);
  localparam int SSH = mt_seed_shift(MT_W);
  localparam int AW  = $clog2(N);
  localparam logic [MT_W-1:0] MULT = MT_W'(mt_seed_mult(MT_W));
  localparam logic [AW-1:0]   LAST = AW'(N - 1);
  localparam logic [AW-1:0]   WRAP = AW'(N - M);

  mt_state_e       state;
  logic [MT_W-1:0] seed_r, prev, cur, tdata_r, seed_next;
  logic [AW-1:0]   idx, k, raddr_a, raddr_b, waddr;
  logic            tvalid_r, we;
  logic [MT_W-1:0] wdata, rd_a, rd_b, twist_new, twist_out;

  assign seed_next = MULT * (prev ^ (prev >> SSH)) + MT_W'(idx);
  assign raddr_a   = (k == LAST) ? '0 : AW'(k + AW'(1));
  assign raddr_b   = (k >= WRAP) ? AW'(k - WRAP) : AW'(k + AW'(M));

  always_comb begin
    we    = 1'b0;
    waddr = k;
    wdata = twist_new;
    case (state)
      ST_LOAD: begin we = 1'b1; waddr = '0;  wdata = seed_r;    end
      ST_SEED: begin we = 1'b1; waddr = idx; wdata = seed_next; end
      ST_CALC: begin we = 1'b1; end
      default: ;
    endcase
  end

  mt_state_ram #(.W(MT_W), .DEPTH(N), .AW(AW)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr_a(raddr_a), .rdata_a(rd_a),
    .raddr_b(raddr_b), .rdata_b(rd_b)
  );

  mt_twist_unit #(.W(MT_W)) u_twist (
    .word_k(cur), .word_k1(rd_a), .word_far(rd_b),
    .word_new(twist_new), .tempered(twist_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_LOAD;
      seed_r   <= INIT_SEED;
      prev     <= '0;
      cur      <= '0;
      idx      <= '0;
      k        <= '0;
      tdata_r  <= '0;
      tvalid_r <= 1'b0;
    end else if (seed_start) begin
      state    <= ST_LOAD;
      seed_r   <= seed_val;
      k        <= '0;
      tvalid_r <= 1'b0;
    end else begin
      case (state)
        ST_LOAD: begin
          prev  <= seed_r;
          cur   <= seed_r;
          idx   <= AW'(1);
          state <= ST_SEED;
        end
        ST_SEED: begin
          prev <= seed_next;
          if (idx == LAST) state <= ST_READ;
          else             idx   <= AW'(idx + AW'(1));
        end
        ST_READ: state <= ST_CALC;
        ST_CALC: begin
          tdata_r  <= twist_out;
          tvalid_r <= 1'b1;
          cur      <= rd_a;
          state    <= ST_SEND;
        end
        ST_SEND: begin
          if (m_tready) begin
            tvalid_r <= 1'b0;
            k        <= (k == LAST) ? '0 : AW'(k + AW'(1));
            state    <= ST_READ;
          end
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  assign busy     = (state == ST_LOAD) || (state == ST_SEED);
  assign m_tdata  = tdata_r;
  assign m_tvalid = tvalid_r;

  // R2
  busy_blocks_valid_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !m_tvalid);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tready && !seed_start) |=> (m_tvalid && $stable(m_tdata)));

  // R6
  reseed_busy_chk: assert property (@(posedge clk) disable iff (rst)
    seed_start |=> busy);

  // R8
  index_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (!(m_tvalid && m_tready) && !seed_start) |=> $stable(k));

  // R4
  index_range_chk: assert property (@(posedge clk) disable iff (rst)
    (k <= LAST) && (idx <= LAST));

endmodule

// File: tb/sim_mt_stream_gen.sv
`timescale 1ns/1ps
module sim_mt_stream_gen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] seed_val = '0;
  logic        seed_start = 1'b0;
  logic        busy;
  logic [31:0] m_tdata;
  logic        m_tvalid;
  logic        m_tready = 1'b0;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  mt_stream_gen #(.MT_W(32), .INIT_SEED(32'd5489)) u0 (
    .clk(clk), .rst(rst), .seed_val(seed_val), .seed_start(seed_start),
    .busy(busy), .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready)
  );

  // batch-regenerating model of the sequence
  bit [31:0] mdl [624];
  int        mi;

  function automatic void mdl_seed(input bit [31:0] s);
    mdl[0] = s;
    for (int i = 1; i < 624; i++)
      mdl[i] = 32'd1812433253 * (mdl[i-1] ^ (mdl[i-1] >> 30)) + 32'(i);
    mi = 624;
  endfunction

  function automatic bit [31:0] mdl_next();
    bit [31:0] y;
    if (mi >= 624) begin
      for (int j = 0; j < 624; j++) begin
        y = {mdl[j][31], mdl[(j + 1) % 624][30:0]};
        mdl[j] = mdl[(j + 397) % 624] ^ (y >> 1) ^ (y[0] ? 32'h9908B0DF : 32'h0);
      end
      mi = 0;
    end
    y  = mdl[mi];
    mi = mi + 1;
    y  = y ^ (y >> 11);
    y  = y ^ ((y << 7) & 32'h9D2C5680);
    y  = y ^ ((y << 15) & 32'hEFC60000);
    y  = y ^ (y >> 18);
    return y;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // mode 0: always ready, 1: 3-of-4 ready, 2: irregular stalls
  task automatic run_words(input int count, input int mode, input string req);
    int        got = 0;
    int        cyc = 0;
    bit        held = 0;
    bit [31:0] hold_val = '0;
    bit        r;
    bit [31:0] e;
    while (got < count) begin
      @(negedge clk);
      cyc++;
      if (cyc > 20 * count + 100) begin
        chk(0, req, got, count);
        return;
      end
      if (held) begin
        chk(m_tvalid && (m_tdata == hold_val), "R7", m_tdata, hold_val);
      end
      case (mode)
        0:       r = 1'b1;
        1:       r = (cyc % 4) != 3;
        default: r = ((cyc * 7 + cyc / 3) % 5) < 2;
      endcase
      m_tready = r;
      if (m_tvalid && r) begin
        e = mdl_next();
        chk(m_tdata == e, req, m_tdata, e);
        held = 0;
        got++;
      end else if (m_tvalid) begin
        held     = 1;
        hold_val = m_tdata;
      end else begin
        held = 0;
      end
    end
    @(negedge clk);
    m_tready = 1'b0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 5000) begin
      if (m_tvalid) chk(0, "R2", 1, 0);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_seed(input bit [31:0] s);
    @(negedge clk);
    seed_val   = s;
    seed_start = 1'b1;
    @(negedge clk);
    seed_start = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b1, "R1", busy, 1);
    chk(m_tvalid == 1'b0, "R1", m_tvalid, 0);
    rst = 1'b0;
    @(negedge clk);
    count_busy(n);
    // R2: N-1 busy cycles after reset release
    chk(n == 623, "R2", n, 623);

    mdl_seed(32'd5489);
    while (!m_tvalid) @(negedge clk);
    // R3: first word for the default seed
    chk(m_tdata == 32'hD091BB5C, "R3", m_tdata, 32'hD091BB5C);
    // R4: long run across the index wrap
    run_words(1300, 0, "R4");

    // R5: run-time reseed under regular backpressure
    pulse_seed(32'h12345678);
    count_busy(n);
    chk(n == 624, "R2", n, 624);
    mdl_seed(32'h12345678);
    run_words(700, 1, "R5");
    // R8: irregular stalls continuing the same sequence
    run_words(700, 2, "R8");

    // R6: reseed while busy
    pulse_seed(32'hCAFEF00D);
    repeat (100) @(negedge clk);
    chk(busy == 1'b1, "R6", busy, 1);
    pulse_seed(32'h00000001);
    count_busy(n);
    chk(n == 624, "R6", n, 624);
    mdl_seed(32'h00000001);
    run_words(60, 2, "R6");

    // R1: reset mid-stream returns to the default seed
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy && !m_tvalid, "R1", {busy, m_tvalid}, 2'b10);
    rst = 1'b0;
    @(negedge clk);
    count_busy(n);
    mdl_seed(32'd5489);
    run_words(40, 1, "R1");

    finish_run();
  end

endmodule